// File: doc/BRIEF.md
# Sideband Message Register Engine

This block lets a host issue one message at a time onto an internal sideband fabric by programming a small bank of registers and then setting a busy bit. Once busy is set, the engine assembles a request from the register contents (destination port, 32-bit offset, opcode, posted flag, byte enables, BAR select, function number and a write payload). It offers that request on a valid/ready port and then waits for a single-beat completion. The returned completion code is then placed in the status register, read data goes into the data register when appropriate, and busy drops.

Software drives the engine by polling. It checks that busy is clear, fills in the routing registers, writes the opcode together with the busy bit, and polls until busy returns to 0. It then reads the 2-bit completion code and, for a read, the data register. A posted request retires as soon as the fabric accepts it. An opcode the engine does not recognise never reaches the fabric.

Top module: `sbmsg_engine`

## Requirements
- R1: After a synchronous reset every register reads 0, busy is 0 and `req_valid` is 0.
- R2: The host register port is byte-addressed with a one-cycle registered read. The mapping is: 0xD0 address (bits 31:24 destination port, bits 15:0 low offset, bits 23:16 stored only); 0xD4 data; 0xD8 status in bits 15:0 (opcode 15:8, posted 7, completion code 2:1, busy 0, bits 6:3 read 0) with the routing ID in bits 31:16 (byte enables 15:12, BAR 10:8, function 7:0 of that half); 0xDC extended address (bits 15:0 become the upper offset). Each write strobe bit enables one byte. The completion-code bits cannot be written. Reads of any other or misaligned address return 0.
- R3: Writing 1 to the busy bit with a valid opcode (taken from the same write if byte 1 is strobed) sets busy and sets the completion code to 1 until the message retires. One cycle later `req_valid` rises. The request carries the register fields, and it holds valid and every field steady until `req_ready` is seen.
- R4: For the write opcodes 1, 5 and 7 the request payload is the data register. For every other opcode the payload is 0.
- R5: A non-posted request waits for `cpl_valid`. On that edge the completion code takes `cpl_status` (0 success, 1 not supported, 2 powered down, 3 multicast mixed) and busy clears.
- R6: For the read opcodes 0, 4 and 6, the data register takes `cpl_data` only when `cpl_status` is 0. In every other case the data register is left as it was.
- R7: A posted request retires on the edge where `req_valid` and `req_ready` are both high. It reports code 0 and does not wait for a completion.
- R8: Setting busy with an opcode outside {0, 1, 4, 5, 6, 7, 13} issues no request. Busy stays 0 and the completion code becomes 1.
- R9: While busy is 1, every host write is ignored. This covers the address, data, routing, extended-address, opcode and posted fields and a second busy set. It also holds in the cycle where the completion clears busy.
- R10: A completion that arrives while no request is waiting for one is dropped. This covers idle time, a request not yet accepted, and after a posted request. Such a completion changes neither status nor data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hst_we | input | 1 | Host write strobe |
| hst_re | input | 1 | Host read strobe |
| hst_addr | input | HADDR_W | Host byte address |
| hst_wstrb | input | 4 | Host byte enables for writes |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Host read data, valid the cycle after `hst_re` |
| req_valid | output | 1 | Request offered to the fabric |
| req_ready | input | 1 | Fabric accepts the request |
| req_port | output | 8 | Destination port |
| req_offset | output | 32 | Register offset within the port |
| req_opcode | output | 8 | Message opcode |
| req_posted | output | 1 | Request needs no completion |
| req_fbe | output | 4 | First byte enables |
| req_bar | output | 3 | BAR select |
| req_fid | output | 8 | Function number |
| req_data | output | 32 | Write payload |
| cpl_valid | input | 1 | Completion beat |
| cpl_status | input | 2 | Completion code |
| cpl_data | input | 32 | Completion read data |

## Verification
The collision of interest is a completion arriving in the same cycle that the host writes the status/routing word, trying both to set busy again and to change the opcode and routing ID. The bench provokes it on purpose by driving `cpl_valid` and `hst_we` on the same edge during a successful config read. It then judges the outcome from the registers read back afterwards. Busy must be clear and the completion code must be the fabric's. The data register must hold the returned data, and the opcode and routing ID must be those of the message just finished. The same check is repeated at random, mixed with posted requests, refused completions and unknown opcodes.

// File: rtl/sbmsg_pkg.sv
package sbmsg_pkg;

  localparam int PORT_W = 8;
  localparam int OP_W   = 8;
  localparam int WORD_W = 32;
  localparam int RID_W  = 16;
  localparam int CC_W   = 2;

  localparam logic [CC_W-1:0] CC_OK    = 2'd0;
  localparam logic [CC_W-1:0] CC_UNSUP = 2'd1;

  localparam logic [OP_W-1:0] OP_MEM_RD  = 8'd0;
  localparam logic [OP_W-1:0] OP_MEM_WR  = 8'd1;
  localparam logic [OP_W-1:0] OP_CFG_RD  = 8'd4;
  localparam logic [OP_W-1:0] OP_CFG_WR  = 8'd5;
  localparam logic [OP_W-1:0] OP_PRV_RD  = 8'd6;
  localparam logic [OP_W-1:0] OP_PRV_WR  = 8'd7;
  localparam logic [OP_W-1:0] OP_PAD_LCK = 8'd13;

  typedef struct packed {
    logic [PORT_W-1:0] port;
    logic [WORD_W-1:0] offset;
    logic [OP_W-1:0]   opcode;
    logic              posted;
    logic [3:0]        fbe;
    logic [2:0]        bar;
    logic [7:0]        fid;
    logic [WORD_W-1:0] payload;
  } sb_req_t;

  function automatic logic op_is_read(input logic [OP_W-1:0] op);
    return (op == OP_MEM_RD) || (op == OP_CFG_RD) || (op == OP_PRV_RD);
  endfunction

  function automatic logic op_is_write(input logic [OP_W-1:0] op);
    return (op == OP_MEM_WR) || (op == OP_CFG_WR) || (op == OP_PRV_WR);
  endfunction

  function automatic logic op_known(input logic [OP_W-1:0] op);
    return op_is_read(op) || op_is_write(op) || (op == OP_PAD_LCK);
  endfunction

endpackage

// File: rtl/sbmsg_regs.sv
module sbmsg_regs
  import sbmsg_pkg::*;
#(
  parameter int HADDR_W   = 8,
  parameter int BASE_ADDR = 'hD0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               hst_we,
  input  logic               hst_re,
  input  logic [HADDR_W-1:0] hst_addr,
  input  logic [3:0]         hst_wstrb,
  input  logic [WORD_W-1:0]  hst_wdata,
  output logic [WORD_W-1:0]  hst_rdata,
  output logic               busy,
  output sb_req_t            req,
  input  logic               done,
  input  logic [CC_W-1:0]    done_code,
  input  logic               load_en,
  input  logic [WORD_W-1:0]  load_data
);

  localparam int W_ADDR = BASE_ADDR / 4;
  localparam int W_DATA = W_ADDR + 1;
  localparam int W_STAT = W_ADDR + 2;
  localparam int W_EXT  = W_ADDR + 3;
  localparam int WA_W   = HADDR_W - 2;

  logic [WORD_W-1:0] addr_q, data_q, ext_q;
  logic [RID_W-1:0]  rid_q;
  logic [OP_W-1:0]   op_q;
  logic              posted_q;
  logic [CC_W-1:0]   code_q;
  logic              busy_q;

  logic [WA_W-1:0] word;
  logic            aligned;
  logic            sel_addr, sel_data, sel_stat, sel_ext;
  logic            wr_ok;
  logic [OP_W-1:0] op_next;
  logic            posted_next;
  logic            go;

  function automatic logic [WORD_W-1:0] merge_bytes(input logic [WORD_W-1:0] cur,
                                                    input logic [WORD_W-1:0] wr,
                                                    input logic [3:0]        strb);
    logic [WORD_W-1:0] res;
    res = cur;
    for (int b = 0; b < 4; b++) begin
      if (strb[b]) res[b*8 +: 8] = wr[b*8 +: 8];
    end
    return res;
  endfunction

  assign word     = hst_addr[HADDR_W-1:2];
  assign aligned  = (hst_addr[1:0] == 2'b00);
  assign sel_addr = aligned && (word == W_ADDR[WA_W-1:0]);
  assign sel_data = aligned && (word == W_DATA[WA_W-1:0]);
  assign sel_stat = aligned && (word == W_STAT[WA_W-1:0]);
  assign sel_ext  = aligned && (word == W_EXT[WA_W-1:0]);

  // Every host write is dropped while a message is in flight.
  assign wr_ok       = hst_we && !busy_q;
  assign op_next     = hst_wstrb[1] ? hst_wdata[15:8] : op_q;
  assign posted_next = hst_wstrb[0] ? hst_wdata[7]    : posted_q;
  assign go          = hst_wstrb[0] && hst_wdata[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q   <= '0;
      data_q   <= '0;
      ext_q    <= '0;
      rid_q    <= '0;
      op_q     <= '0;
      posted_q <= 1'b0;
      code_q   <= CC_OK;
      busy_q   <= 1'b0;
    end else begin
      if (wr_ok && sel_addr) addr_q <= merge_bytes(addr_q, hst_wdata, hst_wstrb);
      if (wr_ok && sel_data) data_q <= merge_bytes(data_q, hst_wdata, hst_wstrb);
      if (wr_ok && sel_ext)  ext_q  <= merge_bytes(ext_q, hst_wdata, hst_wstrb);
      if (wr_ok && sel_stat) begin
        op_q     <= op_next;
        posted_q <= posted_next;
        if (hst_wstrb[2]) rid_q[7:0]  <= hst_wdata[23:16];
        if (hst_wstrb[3]) rid_q[15:8] <= hst_wdata[31:24];
        if (go) begin
          // Unknown opcodes never launch; both paths show "not supported".
          code_q <= CC_UNSUP;
          busy_q <= op_known(op_next);
        end
      end
      if (done) begin
        busy_q <= 1'b0;
        code_q <= done_code;
        if (load_en) data_q <= load_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hst_rdata <= '0;
    end else if (hst_re) begin
      hst_rdata <= '0;
      if (sel_addr) hst_rdata <= addr_q;
      if (sel_data) hst_rdata <= data_q;
      if (sel_ext)  hst_rdata <= ext_q;
      if (sel_stat) hst_rdata <= {rid_q, op_q, posted_q, 4'b0000, code_q, busy_q};
    end
  end

  assign busy        = busy_q;
  assign req.port    = addr_q[31:24];
  assign req.offset  = {ext_q[15:0], addr_q[15:0]};
  assign req.opcode  = op_q;
  assign req.posted  = posted_q;
  assign req.fbe     = rid_q[15:12];
  assign req.bar     = rid_q[10:8];
  assign req.fid     = rid_q[7:0];
  assign req.payload = op_is_write(op_q) ? data_q : '0;

  AST_FIELDS_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (busy_q && $past(busy_q)) |-> ($stable(addr_q) && $stable(rid_q) && $stable(ext_q)
                                   && $stable(op_q) && $stable(posted_q))) else $error("fields changed while busy"); // R9

  AST_BUSY_OPCODE_KNOWN: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> op_known(op_q)) else $error("busy with unknown opcode"); // R8

  AST_DONE_RETIRES: assert property (@(posedge clk) disable iff (rst)
    done |=> (!busy_q && code_q == $past(done_code))) else $error("retire did not clear busy"); // R5

  AST_DATA_ONLY_ON_LOAD: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !load_en) |=> $stable(data_q)) else $error("data changed without load"); // R6

  AST_DONE_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> busy_q) else $error("retire while idle"); // R10

endmodule

// File: rtl/sbmsg_ctrl.sv
module sbmsg_ctrl
  import sbmsg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              busy,
  input  logic [OP_W-1:0]   req_opcode,
  input  logic              req_posted,
  output logic              req_valid,
  input  logic              req_ready,
  input  logic              cpl_valid,
  input  logic [CC_W-1:0]   cpl_status,
  input  logic [WORD_W-1:0] cpl_data,
  output logic              done,
  output logic [CC_W-1:0]   done_code,
  output logic              load_en,
  output logic [WORD_W-1:0] load_data
);

  typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_WAIT} st_t;
  st_t state;

  logic accept, posted_done, cpl_done;

  assign accept      = (state == ST_SEND) && req_ready;
  assign posted_done = accept && req_posted;
  assign cpl_done    = (state == ST_WAIT) && cpl_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: if (busy) state <= ST_SEND;
        ST_SEND: if (req_ready) state <= req_posted ? ST_IDLE : ST_WAIT;
        ST_WAIT: if (cpl_valid) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_valid = (state == ST_SEND);
  assign done      = posted_done || cpl_done;
  assign done_code = posted_done ? CC_OK : cpl_status;
  assign load_en   = cpl_done && op_is_read(req_opcode) && (cpl_status == CC_OK);
  assign load_data = cpl_data;

  AST_REQ_NEEDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE) |-> busy) else $error("request without busy"); // R3

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready) |=> req_valid) else $error("request dropped before accept"); // R3

  AST_POSTED_NO_WAIT: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT) |-> !req_posted) else $error("posted request waiting"); // R7

endmodule

// File: rtl/sbmsg_engine.sv
module sbmsg_engine
  import sbmsg_pkg::*;
#(
  parameter int HADDR_W   = 8,
  parameter int BASE_ADDR = 'hD0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               hst_we,
  input  logic               hst_re,
  input  logic [HADDR_W-1:0] hst_addr,
  input  logic [3:0]         hst_wstrb,
  input  logic [31:0]        hst_wdata,
  output logic [31:0]        hst_rdata,
  output logic               req_valid,
  input  logic               req_ready,
  output logic [7:0]         req_port,
  output logic [31:0]        req_offset,
  output logic [7:0]         req_opcode,
  output logic               req_posted,
  output logic [3:0]         req_fbe,
  output logic [2:0]         req_bar,
  output logic [7:0]         req_fid,
  output logic [31:0]        req_data,
  input  logic               cpl_valid,
  input  logic [1:0]         cpl_status,
  input  logic [31:0]        cpl_data
);

  sb_req_t           req;
  logic              busy;
  logic              done;
  logic [CC_W-1:0]   done_code;
  logic              load_en;
  logic [WORD_W-1:0] load_data;

  sbmsg_regs #(.HADDR_W(HADDR_W), .BASE_ADDR(BASE_ADDR)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .hst_we    (hst_we),
    .hst_re    (hst_re),
    .hst_addr  (hst_addr),
    .hst_wstrb (hst_wstrb),
    .hst_wdata (hst_wdata),
    .hst_rdata (hst_rdata),
    .busy      (busy),
    .req       (req),
    .done      (done),
    .done_code (done_code),
    .load_en   (load_en),
    .load_data (load_data)
  );

  sbmsg_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .busy       (busy),
    .req_opcode (req.opcode),
    .req_posted (req.posted),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .cpl_valid  (cpl_valid),
    .cpl_status (cpl_status),
    .cpl_data   (cpl_data),
    .done       (done),
    .done_code  (done_code),
    .load_en    (load_en),
    .load_data  (load_data)
  );

  assign req_port   = req.port;
  assign req_offset = req.offset;
  assign req_opcode = req.opcode;
  assign req_posted = req.posted;
  assign req_fbe    = req.fbe;
  assign req_bar    = req.bar;
  assign req_fid    = req.fid;
  assign req_data   = req.payload;

  AST_STEADY_REQUEST: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready) |=> ($stable(req_port) && $stable(req_offset) && $stable(req_opcode)
                                   && $stable(req_data) && $stable(req_fid))) else $error("request fields moved"); // R3

endmodule

// File: tb/tb_sbmsg_engine.sv
`timescale 1ns/1ps
module tb_sbmsg_engine;

  localparam logic [7:0] A_ADR = 8'hD0;
  localparam logic [7:0] A_DAT = 8'hD4;
  localparam logic [7:0] A_STA = 8'hD8;
  localparam logic [7:0] A_EXT = 8'hDC;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hst_we = 1'b0, hst_re = 1'b0;
  logic [7:0]  hst_addr = '0;
  logic [3:0]  hst_wstrb = '0;
  logic [31:0] hst_wdata = '0;
  logic [31:0] hst_rdata;
  logic        req_valid, req_ready = 1'b0;
  logic [7:0]  req_port, req_opcode, req_fid;
  logic [31:0] req_offset, req_data;
  logic        req_posted;
  logic [3:0]  req_fbe;
  logic [2:0]  req_bar;
  logic        cpl_valid = 1'b0;
  logic [1:0]  cpl_status = '0;
  logic [31:0] cpl_data = '0;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // shadow of the host-visible state
  logic [31:0] sh_addr, sh_data, sh_ext;
  logic [15:0] sh_rid;
  logic [7:0]  sh_op;
  logic        sh_posted, sh_busy;
  logic [1:0]  sh_code;

  sbmsg_engine dut (
    .clk(clk), .rst(rst), .hst_we(hst_we), .hst_re(hst_re), .hst_addr(hst_addr),
    .hst_wstrb(hst_wstrb), .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_port(req_port),
    .req_offset(req_offset), .req_opcode(req_opcode), .req_posted(req_posted),
    .req_fbe(req_fbe), .req_bar(req_bar), .req_fid(req_fid), .req_data(req_data),
    .cpl_valid(cpl_valid), .cpl_status(cpl_status), .cpl_data(cpl_data)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 150000) begin
      errors = errors + 1;
      $display("FAIL R3 watchdog: ran %0d cycles, expected fewer than %0d", cycles, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic bit is_rd(input logic [7:0] op);
    return op == 8'd0 || op == 8'd4 || op == 8'd6;
  endfunction
  function automatic bit is_wr(input logic [7:0] op);
    return op == 8'd1 || op == 8'd5 || op == 8'd7;
  endfunction
  function automatic bit is_ok(input logic [7:0] op);
    return is_rd(op) || is_wr(op) || op == 8'd13;
  endfunction
  function automatic logic [31:0] stat_word();
    return {sh_rid, sh_op, sh_posted, 4'b0000, sh_code, sh_busy};
  endfunction

  task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic hwrite(input logic [7:0] a, input logic [3:0] s, input logic [31:0] d);
    @(negedge clk);
    hst_we = 1'b1; hst_addr = a; hst_wstrb = s; hst_wdata = d;
    @(negedge clk);
    hst_we = 1'b0;
  endtask

  task automatic hread(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    hst_re = 1'b1; hst_addr = a;
    @(negedge clk);
    hst_re = 1'b0;
    d = hst_rdata;
  endtask

  task automatic verify_regs(input string ctx);
    logic [31:0] r;
    hread(A_ADR, r); check32({"R2 address reg ", ctx}, r, sh_addr);
    hread(A_DAT, r); check32({"R6 data reg ", ctx}, r, sh_data);
    hread(A_STA, r); check32({"R5 status/routing ", ctx}, r, stat_word());
    hread(A_EXT, r); check32({"R2 ext reg ", ctx}, r, sh_ext);
  endtask

  task automatic pulse_cpl(input logic [1:0] st, input logic [31:0] d);
    @(negedge clk);
    cpl_valid = 1'b1; cpl_status = st; cpl_data = d;
    @(negedge clk);
    cpl_valid = 1'b0;
  endtask

  task automatic run_txn(input logic [7:0] port, input logic [31:0] off, input logic [7:0] op,
                         input logic pst, input logic [15:0] rid, input logic [31:0] wd,
                         input logic [1:0] cst, input logic [31:0] cd, input int rdly,
                         input int cdly, input bit stray, input bit poke, input bit collide);
    logic [31:0] junk, r;
    int n;
    bit seen;
    junk = $urandom;
    hwrite(A_ADR, 4'hF, {port, junk[7:0], off[15:0]}); sh_addr = {port, junk[7:0], off[15:0]};
    hwrite(A_EXT, 4'hF, {junk[31:16], off[31:16]});     sh_ext  = {junk[31:16], off[31:16]};
    hwrite(A_DAT, 4'hF, wd);                             sh_data = wd;
    hwrite(A_STA, 4'hF, {rid, op, pst, 6'b000000, 1'b1});
    sh_rid = rid; sh_op = op; sh_posted = pst;
    if (!is_ok(op)) begin
      sh_code = 2'd1; sh_busy = 1'b0;
      seen = 1'b0;
      for (int i = 0; i < 4; i++) begin
        @(negedge clk);
        if (req_valid) seen = 1'b1;
      end
      check32("R8 unknown opcode raised no request", {31'b0, seen}, 32'd0);
    end else begin
      sh_busy = 1'b1; sh_code = 2'd1;
      n = 0;
      while (!req_valid && n < 8) begin
        @(negedge clk);
        n++;
      end
      check32("R3 request raised", {31'b0, req_valid}, 32'd1);
      check32("R3 port", {24'b0, req_port}, {24'b0, port});
      check32("R3 offset", req_offset, off);
      check32("R3 opcode/posted", {23'b0, req_opcode, req_posted}, {23'b0, op, pst});
      check32("R3 routing fields", {17'b0, req_fbe, req_bar, req_fid}, {17'b0, rid[15:12], rid[10:8], rid[7:0]});
      check32("R4 payload", req_data, is_wr(op) ? wd : 32'd0);
      for (int i = 0; i < rdly; i++) begin
        if (stray && i == 0) begin
          cpl_valid = 1'b1; cpl_status = 2'd3; cpl_data = ~cd;
        end
        @(negedge clk);
        cpl_valid = 1'b0;
        check32("R3 request held until ready", {31'b0, req_valid}, 32'd1);
        check32("R3 offset held", req_offset, off);
      end
      req_ready = 1'b1;
      @(negedge clk);
      req_ready = 1'b0;
      if (pst) begin
        sh_busy = 1'b0; sh_code = 2'd0;
        hread(A_STA, r); check32("R7 posted retired at accept", r, stat_word());
        if (stray) pulse_cpl(2'd2, ~cd);
      end else begin
        hread(A_STA, r); check32("R3 busy and code 1 while pending", r, stat_word());
        if (poke) begin
          hwrite(A_ADR, 4'hF, ~sh_addr);
          hwrite(A_DAT, 4'hF, ~sh_data);
          hwrite(A_EXT, 4'hF, ~sh_ext);
          hwrite(A_STA, 4'hF, {~rid, op ^ 8'h01, ~pst, 6'b000000, 1'b1});
          hread(A_STA, r); check32("R9 writes ignored while busy", r, stat_word());
        end
        repeat (cdly) @(negedge clk);
        cpl_valid = 1'b1; cpl_status = cst; cpl_data = cd;
        if (collide) begin
          hst_we = 1'b1; hst_addr = A_STA; hst_wstrb = 4'hF;
          hst_wdata = {~rid, 8'h07, 1'b0, 6'b000000, 1'b1};
        end
        @(negedge clk);
        cpl_valid = 1'b0; hst_we = 1'b0;
        sh_busy = 1'b0; sh_code = cst;
        if (is_rd(op) && cst == 2'd0) sh_data = cd;
      end
    end
    @(negedge clk);
    check32("R3 request idle after retire", {31'b0, req_valid}, 32'd0);
    verify_regs(collide ? "collision" : "after message");
  endtask

  initial begin
    logic [31:0] r;
    logic [7:0] op;
    void'($urandom(32'h5EED_0001));
    sh_addr = '0; sh_data = '0; sh_ext = '0; sh_rid = '0; sh_op = '0;
    sh_posted = 1'b0; sh_busy = 1'b0; sh_code = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check32("R1 request idle at reset", {31'b0, req_valid}, 32'd0);
    verify_regs("R1 reset");

    // R2 byte strobes, unmapped and misaligned reads, read-only code bits
    hwrite(A_ADR, 4'b0010, 32'hAABBCCDD); sh_addr = 32'h0000CC00;
    hread(A_ADR, r); check32("R2 single byte strobe", r, sh_addr);
    hread(8'h40, r); check32("R2 unmapped read", r, 32'd0);
    hread(8'hD5, r); check32("R2 misaligned read", r, 32'd0);
    hwrite(A_STA, 4'b0001, 32'h0000_0006);
    hread(A_STA, r); check32("R2 code bits not writable", r, stat_word());

    // R10 completion while idle
    pulse_cpl(2'd2, 32'h1234_5678);
    verify_regs("R10 idle completion dropped");

    // R6/R9 collision: successful config read, host write in the retire cycle
    run_txn(8'h21, 32'h0001_0040, 8'd4, 1'b0, 16'hF312, 32'h0, 2'd0, 32'hCAFE_0001, 1, 2, 1'b0, 1'b0, 1'b1);
    // R6 read with failure code leaves data alone
    run_txn(8'h22, 32'h0000_0080, 8'd6, 1'b0, 16'h1104, 32'h5555_AAAA, 2'd2, 32'hDEAD_BEEF, 0, 1, 1'b0, 1'b0, 1'b0);
    // R7 posted memory write with stray completion afterwards (R10)
    run_txn(8'h33, 32'hABCD_0010, 8'd1, 1'b1, 16'h8200, 32'h0BAD_F00D, 2'd0, 32'h0, 2, 0, 1'b1, 1'b0, 1'b0);
    // R9 pokes while waiting on a non-posted private write
    run_txn(8'h44, 32'h0000_0ABC, 8'd7, 1'b0, 16'h7001, 32'h1357_9BDF, 2'd3, 32'h0, 0, 1, 1'b0, 1'b1, 1'b0);
    // R8 unknown opcode
    run_txn(8'h55, 32'h0000_0004, 8'd3, 1'b0, 16'h0000, 32'h2468_ACE0, 2'd0, 32'h0, 0, 0, 1'b0, 1'b0, 1'b0);
    // R4 lock opcode carries zero payload; R10 stray during request phase
    run_txn(8'h66, 32'h0000_0100, 8'd13, 1'b0, 16'hF000, 32'hFFFF_FFFF, 2'd0, 32'h7777_7777, 3, 0, 1'b1, 1'b0, 1'b0);

    for (int t = 0; t < 40; t++) begin
      logic [31:0] pick;
      pick = $urandom;
      case (pick[2:0])
        3'd0: op = 8'd0;
        3'd1: op = 8'd1;
        3'd2: op = 8'd4;
        3'd3: op = 8'd5;
        3'd4: op = 8'd6;
        3'd5: op = 8'd7;
        3'd6: op = 8'd13;
        default: op = pick[15:8];
      endcase
      run_txn(pick[31:24], $urandom, op, pick[3], pick[31:16], $urandom, pick[5:4], $urandom,
              int'(pick[7:6]), int'(pick[9:8]), pick[10], pick[11], pick[12]);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule